// File: doc/BRIEF.md
# Complementary PWM Output Stage with Break

This block takes a single PWM reference and turns it into a pair of complementary outputs. Each output has a value pin and an output-enable pin, so the pad cell outside can tri-state it. A five-bit control vector selects how the pair is driven: left undriven, driven at the inactive level, driven from the reference with polarity only, or driven as a complementary pair with dead-time. The five bits are the main enable, the run-mode off-state select, the idle-mode off-state select and the two channel enables.

Two break inputs stop the stage. A break takes both outputs to their inactive levels straight away, through logic alone, without waiting for a clock edge. It also clears the main enable at the next clock edge. After a primary break, and after one dead-time interval, the outputs move to programmed idle levels. A secondary break leaves them at the inactive levels. The main enable stays at 0 until it is written back to 1.

Top module: `cpo_stage`

## Requirements
- R1: With the main enable at 1, both channel enables at 0 and the run off-state select at 0, both output-enables are 0. An output whose output-enable is 0 always shows the value 0.
- R2: With the main enable at 1, exactly one channel enable set and the run off-state select at 0, the enabled output equals the reference XOR that output's polarity bit, with no delay. The other output is undriven.
- R3: With the main enable at 1 and both channel enables set, both outputs are driven. The primary output is the dead-timed reference XOR its polarity bit. The complementary output is the dead-timed inverse of the reference XOR its polarity bit.
- R4: With the main enable at 1 and the run off-state select at 1, every output whose channel enable is 0 is driven at its polarity bit.
- R5: With the main enable at 0 and no break held, both outputs are undriven if the idle off-state select is 0. If it is 1, both outputs are driven at their polarity bits, unless a primary break has moved them to idle levels (R7).
- R6: When a break is active and the idle off-state select is 1, both outputs are driven at their polarity bits in the same cycle as the break, before any clock edge. The one exception is after the idle levels of R7 have been reached.
- R7: Take E as the first clock edge that samples the primary break with the stage disabled or breaking, and D as the dead count. From the D-th edge after E (from E itself when D is 0), an output shows its idle bit XOR its polarity bit, where an idle bit of 1 means active. This lasts until the main enable returns to 1. A secondary break alone never reaches idle levels.
- R8: The secondary break is active only when both off-state selects are 1. Otherwise it has no effect on any output or on the main enable.
- R9: The main enable is 0 after reset. An active break clears it at the next clock edge and wins over a write in the same cycle. Otherwise a write strobe loads the write data.
- R10: Dead-time delays each rising edge of an output's source by D clock edges. A falling edge passes through with no delay. A high pulse shorter than D cycles does not appear. D = 0 passes the source through unchanged. The run counter saturates at its maximum.
- R11: The two outputs are never active at the same time, where active means driven with a value different from the polarity bit. If both idle bits ask for the active level, the complementary output is held inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_ref | input | 1 | PWM reference level |
| en_wr | input | 1 | Write strobe for the main enable |
| en_wdata | input | 1 | Value loaded into the main enable |
| run_off | input | 1 | Run-mode off-state select |
| idle_off | input | 1 | Idle-mode off-state select |
| ena_p | input | 1 | Primary channel enable |
| ena_n | input | 1 | Complementary channel enable |
| pol_p | input | 1 | Primary polarity (inactive level) |
| pol_n | input | 1 | Complementary polarity (inactive level) |
| idle_p | input | 1 | Primary idle request, 1 = active |
| idle_n | input | 1 | Complementary idle request, 1 = active |
| dead_cnt | input | DT_W | Dead-time in clock cycles |
| brk_main | input | 1 | Primary break |
| brk_aux | input | 1 | Secondary break |
| out_p | output | 1 | Primary output value |
| oe_p | output | 1 | Primary output-enable |
| out_n | output | 1 | Complementary output value |
| oe_n | output | 1 | Complementary output-enable |
| main_en | output | 1 | Current main enable |

## Verification
The bench builds the stage with the default dead-count width of 8 bits. Dead counts of 0 check the straight pass-through. Counts from 1 to 7, against reference pulses of 1 to 8 cycles, show pulses being swallowed and rising edges being delayed, and set the wait before idle levels are reached. A count of 255 against a 300-cycle high run brings the saturating counter and the widest delay within reach.

// File: rtl/cpo_pkg.sv
// Package cpo_pkg
// Types shared by the complementary output stage.
// Assumes nothing beyond a single clock domain for the clocked parts.
package cpo_pkg;

    // Break progress: untouched, counting toward idle levels, idle levels shown
    typedef enum logic [1:0] {
        BRK_NONE = 2'd0,
        BRK_WAIT = 2'd1,
        BRK_IDLE = 2'd2
    } brk_phase_t;

    // Drive of one pad: output-enable and value
    typedef struct packed {
        logic oe;
        logic val;
    } pin_drv_t;

endpackage

// File: rtl/cpo_deadband.sv
// Module cpo_deadband
// Delays the rising edge of lvl_in by dead_cnt clock edges. Falling edges pass
// straight through, and a high pulse shorter than dead_cnt cycles is lost.
// Assumes dead_cnt may change at any time; the counter saturates at all-ones.
module cpo_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lvl_in,
    input  logic [DT_W-1:0] dead_cnt,
    output logic            lvl_out
);

    localparam logic [DT_W-1:0] RUN_MAX = '1;

    logic [DT_W-1:0] run_q;

    // Count consecutive edges that sampled lvl_in high, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!lvl_in) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Output is high once the source has been high for dead_cnt edges
    assign lvl_out = lvl_in && (run_q >= dead_cnt);

    // R10: with a non-zero dead count, a high output needs the source high at the previous edge
    a_r10_rise_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_out && dead_cnt != '0) |-> $past(lvl_in));

endmodule

// File: rtl/cpo_brkctl.sv
// Module cpo_brkctl
// Holds the main enable and follows the break sequence. The break qualification
// is combinational, so callers can force outputs before any clock edge. After a
// primary break it counts one dead-time, then reports that idle levels apply.
// Assumes break inputs are already filtered and synchronous enough for sampling.
module cpo_brkctl
    import cpo_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            brk_main,
    input  logic            brk_aux,
    input  logic            run_off,
    input  logic            idle_off,
    input  logic            en_wr,
    input  logic            en_wdata,
    input  logic [DT_W-1:0] dead_cnt,
    output logic            brk_act,
    output logic            main_en,
    output logic            idle_lvl
);

    brk_phase_t      phase_q;
    logic [DT_W-1:0] wait_q;
    logic            en_next;

    // Secondary break counts only when both off-state selects are set
    assign brk_act = brk_main | (brk_aux & run_off & idle_off);

    // Main enable value for the next edge: break first, then the write
    assign en_next = brk_act ? 1'b0 : (en_wr ? en_wdata : main_en);

    // Main enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_en <= 1'b0;
        end else begin
            main_en <= en_next;
        end
    end

    // Break phase and the dead-time wait before idle levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= BRK_NONE;
            wait_q  <= '0;
        end else if (en_next) begin
            phase_q <= BRK_NONE;
        end else begin
            unique case (phase_q)
                BRK_NONE: begin
                    if (brk_main) begin
                        if (dead_cnt == '0) begin
                            phase_q <= BRK_IDLE;
                        end else begin
                            phase_q <= BRK_WAIT;
                            wait_q  <= dead_cnt - 1'b1;
                        end
                    end
                end
                BRK_WAIT: begin
                    if (wait_q == '0) begin
                        phase_q <= BRK_IDLE;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                default: phase_q <= BRK_IDLE;
            endcase
        end
    end

    assign idle_lvl = (phase_q == BRK_IDLE);

    // R9: an active break leaves the main enable cleared after the edge
    a_r9_break_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        brk_act |=> !main_en);

    // R7: idle levels are only reported while the stage is disabled
    a_r7_idle_only_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        idle_lvl |-> !main_en);

endmodule

// File: rtl/cpo_outsel.sv
// Module cpo_outsel
// Decodes the enable and off-state bits into the drive of each pad.
// Purely combinational, so a break reaches the pads without waiting for a clock.
// Assumes dt_p and dt_n are never high together (dead-timed ref and its inverse).
module cpo_outsel
    import cpo_pkg::*;
(
    input  logic eff_en,
    input  logic run_off,
    input  logic idle_off,
    input  logic ena_p,
    input  logic ena_n,
    input  logic pol_p,
    input  logic pol_n,
    input  logic idle_p,
    input  logic idle_n,
    input  logic idle_lvl,
    input  logic ref_lvl,
    input  logic dt_p,
    input  logic dt_n,
    output logic out_p,
    output logic oe_p,
    output logic out_n,
    output logic oe_n
);

    pin_drv_t drv_p, drv_n;

    // Select drive per mode; undriven pads default to value 0
    always_comb begin
        drv_p = '{oe: 1'b0, val: 1'b0};
        drv_n = '{oe: 1'b0, val: 1'b0};
        if (eff_en) begin
            unique case ({ena_p, ena_n})
                2'b11: begin
                    drv_p = '{oe: 1'b1, val: dt_p ^ pol_p};
                    drv_n = '{oe: 1'b1, val: dt_n ^ pol_n};
                end
                2'b10: begin
                    drv_p = '{oe: 1'b1, val: ref_lvl ^ pol_p};
                    if (run_off) drv_n = '{oe: 1'b1, val: pol_n};
                end
                2'b01: begin
                    drv_n = '{oe: 1'b1, val: ref_lvl ^ pol_n};
                    if (run_off) drv_p = '{oe: 1'b1, val: pol_p};
                end
                default: begin
                    if (run_off) begin
                        drv_p = '{oe: 1'b1, val: pol_p};
                        drv_n = '{oe: 1'b1, val: pol_n};
                    end
                end
            endcase
        end else if (idle_off) begin
            if (idle_lvl) begin
                drv_p = '{oe: 1'b1, val: idle_p ^ pol_p};
                drv_n = '{oe: 1'b1, val: (idle_n & ~idle_p) ^ pol_n};
            end else begin
                drv_p = '{oe: 1'b1, val: pol_p};
                drv_n = '{oe: 1'b1, val: pol_n};
            end
        end
    end

    assign out_p = drv_p.val;
    assign oe_p  = drv_p.oe;
    assign out_n = drv_n.val;
    assign oe_n  = drv_n.oe;

endmodule

// File: rtl/cpo_stage.sv
// Module cpo_stage
// Complementary PWM output stage with break handling. Builds two dead-time
// channels (reference and its inverse), the break/enable controller and the
// output decoder. Assumes the reference is synchronous to clk; break inputs may
// act asynchronously on the pads.
module cpo_stage
    import cpo_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_ref,
    input  logic            en_wr,
    input  logic            en_wdata,
    input  logic            run_off,
    input  logic            idle_off,
    input  logic            ena_p,
    input  logic            ena_n,
    input  logic            pol_p,
    input  logic            pol_n,
    input  logic            idle_p,
    input  logic            idle_n,
    input  logic [DT_W-1:0] dead_cnt,
    input  logic            brk_main,
    input  logic            brk_aux,
    output logic            out_p,
    output logic            oe_p,
    output logic            out_n,
    output logic            oe_n,
    output logic            main_en
);

    localparam int NCH = 2;

    logic [NCH-1:0] dt_src;
    logic [NCH-1:0] dt_res;
    logic           brk_act;
    logic           idle_lvl;
    logic           eff_en;

    // Channel 0 delays the reference, channel 1 its inverse
    assign dt_src = {~pwm_ref, pwm_ref};

    for (genvar g = 0; g < NCH; g++) begin : g_dt
        cpo_deadband #(.DT_W(DT_W)) i_dt (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_in  (dt_src[g]),
            .dead_cnt(dead_cnt),
            .lvl_out (dt_res[g])
        );
    end

    cpo_brkctl #(.DT_W(DT_W)) i_brk (
        .clk     (clk),
        .rst_n   (rst_n),
        .brk_main(brk_main),
        .brk_aux (brk_aux),
        .run_off (run_off),
        .idle_off(idle_off),
        .en_wr   (en_wr),
        .en_wdata(en_wdata),
        .dead_cnt(dead_cnt),
        .brk_act (brk_act),
        .main_en (main_en),
        .idle_lvl(idle_lvl)
    );

    // An active break masks the enable before the register catches up
    assign eff_en = main_en & ~brk_act;

    cpo_outsel i_sel (
        .eff_en  (eff_en),
        .run_off (run_off),
        .idle_off(idle_off),
        .ena_p   (ena_p),
        .ena_n   (ena_n),
        .pol_p   (pol_p),
        .pol_n   (pol_n),
        .idle_p  (idle_p),
        .idle_n  (idle_n),
        .idle_lvl(idle_lvl),
        .ref_lvl (pwm_ref),
        .dt_p    (dt_res[0]),
        .dt_n    (dt_res[1]),
        .out_p   (out_p),
        .oe_p    (oe_p),
        .out_n   (out_n),
        .oe_n    (oe_n)
    );

    // R11: the pads are never both driven to their active level
    a_r11_never_both_active: assert property (@(posedge clk) disable iff (!rst_n)
        !((oe_p && (out_p != pol_p)) && (oe_n && (out_n != pol_n))));

    // R1: an undriven pad always shows value 0
    a_r1_undriven_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_p |-> !out_p) and (!oe_n |-> !out_n));

    // R6: a break with the idle off-state select forces the inactive levels
    a_r6_break_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_act && idle_off && !idle_lvl) |->
            (oe_p && out_p == pol_p && oe_n && out_n == pol_n));

endmodule

// File: tb/test_cpo_stage.sv
module test_cpo_stage;

    localparam int DT_W = 8;
    localparam int SAT  = (1 << DT_W) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwm_ref = 1'b0;
    logic            en_wr = 1'b0;
    logic            en_wdata = 1'b0;
    logic            run_off = 1'b0;
    logic            idle_off = 1'b0;
    logic            ena_p = 1'b0;
    logic            ena_n = 1'b0;
    logic            pol_p = 1'b0;
    logic            pol_n = 1'b0;
    logic            idle_p = 1'b0;
    logic            idle_n = 1'b0;
    logic [DT_W-1:0] dead_cnt = '0;
    logic            brk_main = 1'b0;
    logic            brk_aux = 1'b0;
    logic            out_p, oe_p, out_n, oe_n, main_en;

    always #5 clk = ~clk;

    cpo_stage #(.DT_W(DT_W)) i_cpo_stage (
        .clk(clk), .rst_n(rst_n), .pwm_ref(pwm_ref), .en_wr(en_wr), .en_wdata(en_wdata),
        .run_off(run_off), .idle_off(idle_off), .ena_p(ena_p), .ena_n(ena_n),
        .pol_p(pol_p), .pol_n(pol_n), .idle_p(idle_p), .idle_n(idle_n),
        .dead_cnt(dead_cnt), .brk_main(brk_main), .brk_aux(brk_aux),
        .out_p(out_p), .oe_p(oe_p), .out_n(out_n), .oe_n(oe_n), .main_en(main_en)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // Behavioural model state
    bit m_en = 1'b0;
    int m_hi = 0;
    int m_lo = 0;
    int m_phase = 0;   // 0 none, 1 counting, 2 idle levels
    int m_cnt = 0;

    function automatic bit brk_now();
        return brk_main | (brk_aux & run_off & idle_off);
    endfunction

    // Model update on every clock edge
    always @(posedge clk) begin
        bit b, nen;
        if (!rst_n) begin
            m_en = 0; m_hi = 0; m_lo = 0; m_phase = 0; m_cnt = 0;
        end else begin
            b = brk_now();
            nen = b ? 1'b0 : (en_wr ? en_wdata : m_en);
            if (nen) m_phase = 0;
            else if (m_phase == 0) begin
                if (brk_main) begin
                    if (dead_cnt == 0) m_phase = 2;
                    else begin m_phase = 1; m_cnt = int'(dead_cnt) - 1; end
                end
            end else if (m_phase == 1) begin
                if (m_cnt == 0) m_phase = 2; else m_cnt = m_cnt - 1;
            end
            m_en = nen;
            m_hi = pwm_ref ? ((m_hi < SAT) ? m_hi + 1 : SAT) : 0;
            m_lo = !pwm_ref ? ((m_lo < SAT) ? m_lo + 1 : SAT) : 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Compare against the model every cycle, after the inputs have settled
    always @(negedge clk) begin
        bit b, eff, dp, dn;
        logic [3:0] e;
        string tag;
        #2;
        if (cmp_on && !done) begin
            b = brk_now();
            eff = m_en & !b;
            dp = pwm_ref && (m_hi >= int'(dead_cnt));
            dn = !pwm_ref && (m_lo >= int'(dead_cnt));
            e = 4'b0000; // {oe_p, out_p, oe_n, out_n}
            if (eff) begin
                if (ena_p && ena_n) begin
                    e = {1'b1, dp ^ pol_p, 1'b1, dn ^ pol_n}; tag = "R3 R10";
                end else if (ena_p) begin
                    e = {1'b1, pwm_ref ^ pol_p, run_off, run_off & pol_n};
                    tag = run_off ? "R4" : "R2";
                end else if (ena_n) begin
                    e = {run_off, run_off & pol_p, 1'b1, pwm_ref ^ pol_n};
                    tag = run_off ? "R4" : "R2";
                end else begin
                    e = {run_off, run_off & pol_p, run_off, run_off & pol_n};
                    tag = run_off ? "R4" : "R1";
                end
            end else if (idle_off) begin
                if (m_phase == 2) begin
                    e = {1'b1, idle_p ^ pol_p, 1'b1, (idle_n & !idle_p) ^ pol_n};
                    tag = "R7";
                end else begin
                    e = {1'b1, pol_p, 1'b1, pol_n};
                    tag = b ? "R6" : "R5";
                end
            end else begin
                tag = "R5";
            end
            if (brk_aux && !(run_off && idle_off)) tag = {tag, " R8"};
            chk(tag, {oe_p, out_p, oe_n, out_n}, e);
            chk("R9 main enable", main_en, m_en);
            chk("R11 exclusive active", (oe_p && out_p != pol_p) && (oe_n && out_n != pol_n), 0);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hold(bit v, int n);
        pwm_ref = v;
        step(n);
    endtask

    task automatic write_en(bit v);
        en_wr = 1'b1; en_wdata = v;
        step(1);
        en_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog expired, run hung (all requirements)");
        finish_run();
    end

    initial begin
        step(3);
        cmp_on = 1'b1;          // reset state: main enable 0, undriven (R5, R9)
        step(2);
        rst_n = 1'b1;
        step(2);
        idle_off = 1'b1;        // disabled, driven inactive (R5)
        pol_p = 1'b1;
        step(2);
        idle_off = 1'b0; pol_p = 1'b0;
        write_en(1'b1);
        // R1: no channel enabled, no run off-state
        hold(1, 3); hold(0, 3);
        // R2: primary only, then complementary only, with polarity
        ena_p = 1; hold(1, 3); hold(0, 2); pol_p = 1; hold(1, 2); hold(0, 2);
        ena_p = 0; ena_n = 1; hold(1, 3); hold(0, 2); pol_n = 1; hold(1, 2); hold(0, 2);
        // R4: run off-state drives the disabled output
        run_off = 1; hold(1, 3); hold(0, 3);
        ena_n = 0; ena_p = 1; hold(1, 3); hold(0, 3);
        ena_p = 0; hold(1, 2); hold(0, 2);
        run_off = 0; pol_p = 0; pol_n = 0;
        // R3, R10: complementary with dead-time, pulses of growing length
        ena_p = 1; ena_n = 1; dead_cnt = 3;
        for (int len = 1; len <= 6; len++) begin
            hold(1, len); hold(0, len);
        end
        dead_cnt = 0;
        for (int len = 1; len <= 3; len++) begin
            hold(1, len); hold(0, len);
        end
        pol_n = 1; dead_cnt = 2; hold(1, 5); hold(0, 5);
        pol_n = 0;
        // R10: widest dead-time and counter saturation
        dead_cnt = 8'd255; hold(1, 300); hold(0, 4); hold(1, 10);
        dead_cnt = 8'd2; hold(0, 5); hold(1, 5);
        // R6, R7, R9: primary break with idle off-state select
        idle_off = 1; idle_p = 0; idle_n = 1; dead_cnt = 4;
        brk_main = 1; en_wr = 1; en_wdata = 1; step(1); en_wr = 0;
        step(2); brk_main = 0; hold(0, 6); hold(1, 4);
        write_en(1'b1); hold(0, 3);
        // R7, R11: both idle bits request active, D = 0
        idle_p = 1; idle_n = 1; dead_cnt = 0;
        brk_main = 1; step(1); brk_main = 0; step(4);
        write_en(1'b1); step(2);
        // R8: secondary break ignored, then honoured
        run_off = 0; brk_aux = 1; hold(1, 3); hold(0, 2); brk_aux = 0;
        run_off = 1; brk_aux = 1; step(1); brk_aux = 0; step(8);
        write_en(1'b1); step(2);
        // R5: disabled with idle off-state select at 0
        idle_off = 0; brk_main = 1; step(1); brk_main = 0; step(3);
        write_en(1'b1);
        // Randomised sequences over all mode bits (R11)
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 40) == 0) begin
                {run_off, idle_off, ena_p, ena_n, pol_p, pol_n, idle_p, idle_n} = 8'($urandom);
                dead_cnt = DT_W'($urandom % 8);
            end
            pwm_ref  = (($urandom % 3) == 0) ? ~pwm_ref : pwm_ref;
            brk_main = (($urandom % 90) == 0);
            brk_aux  = (($urandom % 70) == 0);
            en_wr    = (($urandom % 25) == 0);
            en_wdata = (($urandom % 4) != 0);
            step(1);
        end
        brk_main = 0; brk_aux = 0; en_wr = 0;
        step(2);
        finish_run();
    end

endmodule